// File: doc/BRIEF.md
# Tiled Background Pixel Fetcher

This block produces one pixel of a tiled background layer on each request. A request carries a screen pixel position together with the layer settings: the horizontal and vertical scroll, a two-bit code for the map size, the map and tile-data base block numbers, and the pixel format. The block adds the scroll to the position and wraps the result to the map size. It reads the 16-bit map entry for the tile under that point. It then reads the halfword of tile pixel data that holds the pixel and returns a palette index with a transparent flag.

Memory is reached through a synchronous read port. The block raises a request for one cycle with a byte address. The halfword at that address must be on the data input a fixed number of cycles later, set by `MEM_LAT`. All addresses are relative to the start of video memory. The result leaves through a valid/ready handshake. One request is in flight at a time.

Top module: `bg_tile_fetch`

## Requirements
- R1: During and after reset, `req_ready` is 1 and both `pix_valid` and `mem_req` are 0.
- R2: A request is taken on a cycle with `req_valid` and `req_ready` both high. `req_ready` stays low until the pixel is handed over. Each pixel makes exactly two reads, the map entry first and the tile data second. `mem_req` is high for single cycles only, and every address is even.
- R3: For a read requested in cycle c, the design uses `mem_rdata` as presented in cycle c+`MEM_LAT`.
- R4: The map width is 512 pixels when `map_size[0]`=1 and 256 otherwise. The map height is 512 pixels when `map_size[1]`=1 and 256 otherwise. The map point is ((x+hscroll) mod width, (y+vscroll) mod height).
- R5: Map tiles are 8x8 pixels. The map is made of 32x32-entry blocks of 0x800 bytes, numbered left to right and then top to bottom. The entry address is (map_base + block)*0x800 + (row*32 + column)*2, where row and column are taken mod 32 inside the block.
- R6: A map entry holds the tile number in bits 9:0, a horizontal mirror in bit 10, a vertical mirror in bit 11 and the palette bank in bits 15:12.
- R7: The horizontal mirror replaces the pixel column c inside the tile with 7-c. The vertical mirror does the same for the pixel row.
- R8: With `color8`=0 (4 bits per pixel), a tile takes 32 bytes. The pixel is at byte tile_base*0x4000 + tile*32 + row*4 + column/2. In each byte the low nibble is the left pixel. The read goes to the even halfword containing that byte.
- R9: With `color8`=1 (8 bits per pixel), a tile takes 64 bytes. The pixel is at byte tile_base*0x4000 + tile*64 + row*8 + column. An even byte is bits 7:0 of the halfword and an odd byte is bits 15:8.
- R10: In 4-bit mode `pix_index` = bank*16 + nibble. In 8-bit mode `pix_index` is the byte read.
- R11: `pix_transparent` is 1 exactly when the colour number read (nibble or byte) is 0, whatever the bank.
- R12: While `pix_valid` is high and `pix_ready` is low, the output holds. Request and layer inputs that change after acceptance have no effect on the pixel in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Pixel request present |
| req_ready | output | 1 | Block idle, request can be taken |
| scr_x | input | 8 | Screen pixel column |
| scr_y | input | 8 | Screen pixel row |
| hscroll | input | 9 | Horizontal scroll offset |
| vscroll | input | 9 | Vertical scroll offset |
| map_size | input | 2 | Map size code (bit 0 wide, bit 1 tall) |
| map_base | input | 5 | Map start in 0x800-byte blocks |
| tile_base | input | 2 | Tile data start in 0x4000-byte blocks |
| color8 | input | 1 | 1 = 8 bits per pixel, 0 = 4 bits per pixel |
| mem_req | output | 1 | Read request, one cycle |
| mem_addr | output | 17 | Byte address of the halfword read |
| mem_rdata | input | 16 | Read data, valid MEM_LAT cycles after the request |
| pix_valid | output | 1 | Pixel result present |
| pix_ready | input | 1 | Consumer takes the pixel |
| pix_index | output | 8 | Palette index |
| pix_transparent | output | 1 | Colour number was 0 |

## Verification
Random positions, scrolls, size codes, base blocks and formats are driven against a memory whose content is a hash of the address. Each read address and the final index are compared with a model. This separates errors in wrap, block numbering, mirroring and nibble or byte choice, because each one sends a read to a different address or picks a different field. Fixed memory words are used for the directed cases. One has bank 15 with a zero nibble next to a nonzero one, which shows that the bank does not affect transparency. Others cover 8-bit zero and nonzero bytes and large scroll values that wrap. Read data outside the latency slot returns a marker value, so capturing a cycle early or late gives a wrong index. Layer inputs are changed at random while a pixel is in flight, and the consumer stalls for random lengths.

// File: rtl/bg_fetch_pkg.sv
package bg_fetch_pkg;

    localparam int MAP_PIX_W     = 9;        // map coordinates up to 512 pixels
    localparam int MAP_BLK_BYTES = 32'h800;  // one 32x32-entry map block
    localparam int CHR_BLK_BYTES = 32'h4000; // one tile data block

    typedef enum logic [2:0] {
        S_IDLE,
        S_MAP_REQ,
        S_MAP_WAIT,
        S_TILE_REQ,
        S_TILE_WAIT,
        S_OUT
    } fetch_state_e;

    // 16-bit map entry, most significant field first
    typedef struct packed {
        logic [3:0] bank;
        logic       vflip;
        logic       hflip;
        logic [9:0] tile;
    } map_entry_t;

    typedef struct packed {
        logic [1:0] size;
        logic [4:0] map_blk;
        logic [1:0] chr_blk;
        logic       color8;
    } layer_cfg_t;

    function automatic logic [2:0] mirror3(input logic [2:0] v, input logic flip);
        return v ^ {3{flip}};
    endfunction

endpackage

// File: rtl/bg_coord_wrap.sv
module bg_coord_wrap
    import bg_fetch_pkg::*;
#(
    parameter int SCR_W = 8
) (
    input  logic [SCR_W-1:0]     scr,
    input  logic [MAP_PIX_W-1:0] scroll,
    input  logic                 big,
    output logic [MAP_PIX_W-1:0] pos
);
    logic [MAP_PIX_W-1:0] sum;

    assign sum = MAP_PIX_W'(scr) + scroll;
    assign pos = big ? sum : {1'b0, sum[MAP_PIX_W-2:0]};
endmodule

// File: rtl/bg_addr_gen.sv
module bg_addr_gen
    import bg_fetch_pkg::*;
#(
    parameter int ADDR_W = 17
) (
    input  logic [MAP_PIX_W-1:0] sx,
    input  logic [MAP_PIX_W-1:0] sy,
    input  logic                 wide,
    input  logic [4:0]           map_blk,
    input  logic [1:0]           chr_blk,
    input  logic                 color8,
    input  map_entry_t           entry,
    output logic [ADDR_W-1:0]    map_addr,
    output logic [ADDR_W-1:0]    tile_addr,
    output logic [2:0]           col
);
    logic [5:0]  tx, ty;
    logic [1:0]  blk;
    logic [2:0]  row;
    logic [31:0] map_off, chr_off;

    assign tx  = sx[8:3];
    assign ty  = sy[8:3];
    assign blk = wide ? {ty[5], tx[5]} : {1'b0, ty[5]};

    assign map_off  = (32'(map_blk) + 32'(blk)) * MAP_BLK_BYTES
                    + 32'({ty[4:0], tx[4:0], 1'b0});
    assign map_addr = ADDR_W'(map_off);

    assign col = mirror3(sx[2:0], entry.hflip);
    assign row = mirror3(sy[2:0], entry.vflip);

    always_comb begin
        if (color8)
            chr_off = 32'({entry.tile, 6'b0}) + 32'({row, 3'b0}) + 32'({col[2:1], 1'b0});
        else
            chr_off = 32'({entry.tile, 5'b0}) + 32'({row, 2'b0}) + 32'({col[2], 1'b0});
    end

    assign tile_addr = ADDR_W'(32'(chr_blk) * CHR_BLK_BYTES + chr_off);
endmodule

// File: rtl/bg_pixel_pick.sv
module bg_pixel_pick (
    input  logic        color8,
    input  logic [3:0]  bank,
    input  logic [2:0]  col,
    input  logic [15:0] hw,
    output logic [7:0]  index,
    output logic        transp
);
    logic [15:0] shifted;
    logic [7:0]  byte_v;
    logic [3:0]  nib;

    assign shifted = hw >> {col[1:0], 2'b00};
    assign nib     = shifted[3:0];
    assign byte_v  = col[0] ? hw[15:8] : hw[7:0];

    always_comb begin
        if (color8) begin
            index  = byte_v;
            transp = (byte_v == 8'd0);
        end else begin
            index  = {bank, nib};
            transp = (nib == 4'd0);
        end
    end
endmodule

// File: rtl/bg_tile_fetch.sv
module bg_tile_fetch
    import bg_fetch_pkg::*;
#(
    parameter int ADDR_W  = 17,
    parameter int MEM_LAT = 2,
    parameter int SCR_W   = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [SCR_W-1:0]     scr_x,
    input  logic [SCR_W-1:0]     scr_y,
    input  logic [MAP_PIX_W-1:0] hscroll,
    input  logic [MAP_PIX_W-1:0] vscroll,
    input  logic [1:0]           map_size,
    input  logic [4:0]           map_base,
    input  logic [1:0]           tile_base,
    input  logic                 color8,
    output logic                 mem_req,
    output logic [ADDR_W-1:0]    mem_addr,
    input  logic [15:0]          mem_rdata,
    output logic                 pix_valid,
    input  logic                 pix_ready,
    output logic [7:0]           pix_index,
    output logic                 pix_transparent
);
    localparam int CNT_W = $clog2(MEM_LAT + 1);

    fetch_state_e         state;
    logic [CNT_W-1:0]     lat_cnt;
    logic                 lat_done;
    layer_cfg_t           cfg_q;
    map_entry_t           entry_q;
    logic [MAP_PIX_W-1:0] sx_w, sy_w, sx_q, sy_q;
    logic [ADDR_W-1:0]    map_addr, tile_addr;
    logic [2:0]           col;
    logic [7:0]           pick_idx, idx_q;
    logic                 pick_tr, tr_q;

    bg_coord_wrap #(.SCR_W(SCR_W)) u_wrap_x (
        .scr(scr_x), .scroll(hscroll), .big(map_size[0]), .pos(sx_w)
    );
    bg_coord_wrap #(.SCR_W(SCR_W)) u_wrap_y (
        .scr(scr_y), .scroll(vscroll), .big(map_size[1]), .pos(sy_w)
    );

    bg_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
        .sx(sx_q), .sy(sy_q), .wide(cfg_q.size[0]),
        .map_blk(cfg_q.map_blk), .chr_blk(cfg_q.chr_blk), .color8(cfg_q.color8),
        .entry(entry_q), .map_addr(map_addr), .tile_addr(tile_addr), .col(col)
    );

    bg_pixel_pick u_pick (
        .color8(cfg_q.color8), .bank(entry_q.bank), .col(col),
        .hw(mem_rdata), .index(pick_idx), .transp(pick_tr)
    );

    assign lat_done        = (lat_cnt == CNT_W'(MEM_LAT));
    assign req_ready       = (state == S_IDLE);
    assign mem_req         = (state == S_MAP_REQ) || (state == S_TILE_REQ);
    assign mem_addr        = (state == S_MAP_REQ) ? map_addr : tile_addr;
    assign pix_valid       = (state == S_OUT);
    assign pix_index       = idx_q;
    assign pix_transparent = tr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= S_IDLE;
            lat_cnt <= '0;
            cfg_q   <= '0;
            entry_q <= '0;
            sx_q    <= '0;
            sy_q    <= '0;
            idx_q   <= '0;
            tr_q    <= 1'b0;
        end else begin
            case (state)
                S_IDLE: if (req_valid) begin
                    sx_q  <= sx_w;
                    sy_q  <= sy_w;
                    cfg_q <= '{size: map_size, map_blk: map_base,
                               chr_blk: tile_base, color8: color8};
                    state <= S_MAP_REQ;
                end
                S_MAP_REQ: begin
                    lat_cnt <= CNT_W'(1);
                    state   <= S_MAP_WAIT;
                end
                S_MAP_WAIT: begin
                    if (lat_done) begin
                        entry_q <= map_entry_t'(mem_rdata);
                        state   <= S_TILE_REQ;
                    end else begin
                        lat_cnt <= lat_cnt + CNT_W'(1);
                    end
                end
                S_TILE_REQ: begin
                    lat_cnt <= CNT_W'(1);
                    state   <= S_TILE_WAIT;
                end
                S_TILE_WAIT: begin
                    if (lat_done) begin
                        idx_q <= pick_idx;
                        tr_q  <= pick_tr;
                        state <= S_OUT;
                    end else begin
                        lat_cnt <= lat_cnt + CNT_W'(1);
                    end
                end
                S_OUT: if (pix_ready) state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    // R2: read strobes are isolated single cycles on even addresses
    p_single_req_r2: assert property (@(posedge clk) disable iff (rst)
        mem_req |=> !mem_req);
    p_even_addr_r2: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (mem_addr[0] == 1'b0));
    p_busy_r2: assert property (@(posedge clk) disable iff (rst)
        pix_valid |-> !req_ready);

    // R5: the map read stays inside the map span chosen by the size code
    p_map_span_r5: assert property (@(posedge clk) disable iff (rst)
        (state == S_MAP_REQ) |->
            ((int'(mem_addr) >= int'(cfg_q.map_blk) * MAP_BLK_BYTES) &&
             (int'(mem_addr) < int'(cfg_q.map_blk) * MAP_BLK_BYTES
                 + (MAP_BLK_BYTES << (int'(cfg_q.size[0]) + int'(cfg_q.size[1]))))));

    // R8: the tile read starts no lower than the tile data block
    p_tile_floor_r8: assert property (@(posedge clk) disable iff (rst)
        (state == S_TILE_REQ) |-> (int'(mem_addr) >= int'(cfg_q.chr_blk) * CHR_BLK_BYTES));

    // R11: a zero index is always flagged transparent
    p_zero_transp_r11: assert property (@(posedge clk) disable iff (rst)
        (pix_valid && pix_index == 8'd0) |-> pix_transparent);

    // R12: output holds under back-pressure
    p_hold_r12: assert property (@(posedge clk) disable iff (rst)
        (pix_valid && !pix_ready) |=>
            (pix_valid && $stable(pix_index) && $stable(pix_transparent)));
endmodule

// File: tb/bg_tile_fetch_test.sv
`timescale 1ns/1ps
module bg_tile_fetch_test;
    localparam int ADDR_W  = 17;
    localparam int MEM_LAT = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [7:0]  scr_x = '0, scr_y = '0;
    logic [8:0]  hscroll = '0, vscroll = '0;
    logic [1:0]  map_size = '0;
    logic [4:0]  map_base = '0;
    logic [1:0]  tile_base = '0;
    logic        color8 = 1'b0;
    logic        mem_req;
    logic [ADDR_W-1:0] mem_addr;
    logic [15:0] mem_rdata;
    logic        pix_valid;
    logic        pix_ready = 1'b0;
    logic [7:0]  pix_index;
    logic        pix_transparent;

    int checks = 0;
    int errors = 0;
    bit ovr_en = 1'b0;
    logic [15:0] ovr_val = '0;

    always #4 clk = ~clk;

    bg_tile_fetch #(.ADDR_W(ADDR_W), .MEM_LAT(MEM_LAT)) uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .scr_x(scr_x), .scr_y(scr_y), .hscroll(hscroll), .vscroll(vscroll),
        .map_size(map_size), .map_base(map_base), .tile_base(tile_base),
        .color8(color8), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .pix_valid(pix_valid), .pix_ready(pix_ready),
        .pix_index(pix_index), .pix_transparent(pix_transparent)
    );

    function automatic logic [15:0] memf(input int a);
        int h;
        h = (a >>> 1) * 40503 + 12345;
        h = h ^ (h >>> 7);
        return h[15:0];
    endfunction

    function automatic logic [15:0] memv(input int a);
        return ovr_en ? ovr_val : memf(a);
    endfunction

    // memory model: data valid exactly MEM_LAT cycles after the request
    logic [ADDR_W-1:0] pa [MEM_LAT];
    logic              pv [MEM_LAT];
    always @(posedge clk) begin
        pa[0] <= mem_addr;
        pv[0] <= mem_req;
        for (int i = 1; i < MEM_LAT; i++) begin
            pa[i] <= pa[i-1];
            pv[i] <= pv[i-1];
        end
    end
    assign mem_rdata = pv[MEM_LAT-1] ? memv(int'(pa[MEM_LAT-1])) : 16'hDEAD;

    // read address monitor
    int req_total = 0;
    int rec [4];
    always @(negedge clk) begin
        if (!rst && mem_req) begin
            rec[req_total % 4] = int'(mem_addr);
            req_total = req_total + 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run_px(input int x, input int y, input int hs, input int vs,
                          input int sz, input int mb, input int tb, input int c8,
                          input int hold, input bit scramble);
        int w, h, sx, sy, tx, ty, blk, maddr, ent, tile, hf, vf, bank;
        int px, py, boff, taddr, hw, cnum, eidx, etr, base, waited;
        w  = sz[0] ? 512 : 256;
        h  = sz[1] ? 512 : 256;
        sx = (x + hs) % w;
        sy = (y + vs) % h;
        tx = sx / 8;  ty = sy / 8;
        blk = (ty / 32) * (w / 256) + tx / 32;
        maddr = ((mb + blk) * 2048 + ((ty % 32) * 32 + (tx % 32)) * 2) % (1 << ADDR_W);
        ent  = int'(memv(maddr));
        tile = ent & 1023;
        hf   = (ent >> 10) & 1;
        vf   = (ent >> 11) & 1;
        bank = (ent >> 12) & 15;
        px = hf ? 7 - (sx % 8) : sx % 8;
        py = vf ? 7 - (sy % 8) : sy % 8;
        if (c8 != 0) begin
            boff  = tb * 16384 + tile * 64 + py * 8 + px;
            taddr = (boff & ~1) % (1 << ADDR_W);
            hw    = int'(memv(taddr));
            cnum  = (hw >> ((px % 2) * 8)) & 255;
            eidx  = cnum;
        end else begin
            boff  = tb * 16384 + tile * 32 + py * 4 + px / 2;
            taddr = (boff & ~1) % (1 << ADDR_W);
            hw    = int'(memv(taddr));
            cnum  = (hw >> ((px % 4) * 4)) & 15;
            eidx  = bank * 16 + cnum;
        end
        etr = (cnum == 0) ? 1 : 0;

        @(negedge clk);
        chk(req_ready == 1'b1, "R2 idle ready", int'(req_ready), 1);
        base = req_total;
        scr_x = 8'(x); scr_y = 8'(y); hscroll = 9'(hs); vscroll = 9'(vs);
        map_size = 2'(sz); map_base = 5'(mb); tile_base = 2'(tb); color8 = 1'(c8);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R2 busy after accept", int'(req_ready), 0);
        if (scramble) begin  // R12: later input changes must not matter
            scr_x = 8'($urandom); scr_y = 8'($urandom);
            hscroll = 9'($urandom); vscroll = 9'($urandom);
            map_size = 2'($urandom); map_base = 5'($urandom);
            tile_base = 2'($urandom); color8 = 1'($urandom);
        end
        waited = 0;
        while (!pix_valid && waited < 100) begin
            @(negedge clk);
            waited++;
        end
        if (!pix_valid) begin
            chk(1'b0, "R2 pixel timeout", 0, 1);
            return;
        end
        for (int k = 0; k < hold; k++) @(negedge clk);
        chk(pix_valid == 1'b1, "R12 valid held", int'(pix_valid), 1);
        chk(req_total - base == 2, "R2 read count", req_total - base, 2);
        chk(rec[base % 4] == maddr, "R4 R5 map address", rec[base % 4], maddr);
        chk(rec[(base + 1) % 4] == taddr,
            c8 != 0 ? "R6 R7 R9 tile address" : "R6 R7 R8 tile address",
            rec[(base + 1) % 4], taddr);
        chk(int'(pix_index) == eidx, "R3 R10 R12 index", int'(pix_index), eidx);
        chk(int'(pix_transparent) == etr, "R11 transparent", int'(pix_transparent), etr);
        pix_ready = 1'b1;
        @(negedge clk);
        pix_ready = 1'b0;
        chk(pix_valid == 1'b0, "R2 handed over", int'(pix_valid), 0);
    endtask

    bit done = 1'b0;

    initial begin
        void'($urandom(32'h1234));
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1 && pix_valid == 1'b0 && mem_req == 1'b0,
            "R1 during reset", {int'(req_ready), int'(pix_valid), int'(mem_req)}, 4);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready == 1'b1 && pix_valid == 1'b0 && mem_req == 1'b0,
            "R1 after reset", {int'(req_ready), int'(pix_valid), int'(mem_req)}, 4);

        // R11 / R10: bank 15, zero nibble vs nonzero nibble
        ovr_en = 1'b1; ovr_val = 16'hF000;
        run_px(0, 0, 0, 0, 0, 0, 0, 0, 0, 1'b0);
        run_px(3, 0, 0, 0, 0, 0, 0, 0, 2, 1'b0);
        // R9 / R11: 8-bit zero byte and nonzero byte
        ovr_val = 16'h0000;
        run_px(5, 9, 0, 0, 0, 0, 1, 1, 0, 1'b0);
        ovr_val = 16'h00F0;
        run_px(0, 0, 0, 0, 0, 3, 1, 1, 1, 1'b0);
        ovr_en = 1'b0;

        // R4: wrap under each size code, and largest scroll values
        for (int s = 0; s < 4; s++) begin
            run_px(200, 180, 100, 120, s, 4, 2, 0, 0, 1'b0);
            run_px(255, 255, 511, 511, s, 31, 3, s % 2, 1, 1'b0);
        end

        // random mix, inputs scrambled while busy
        for (int n = 0; n < 300; n++) begin
            run_px(int'($urandom_range(255)), int'($urandom_range(255)),
                   int'($urandom_range(511)), int'($urandom_range(511)),
                   int'($urandom_range(3)), int'($urandom_range(31)),
                   int'($urandom_range(3)), int'($urandom_range(1)),
                   int'($urandom_range(3)), 1'b1);
        end

        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL R2 watchdog expired actual=0 expected=1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule